// File: doc/BRIEF.md
# Video Memory Data-Port Read Engine

This block answers processor reads on the data port of a video processor. When a read is accepted it clears the control-word pending flag. If the latched command code is in write mode, it answers at once with zero. Otherwise it waits until the write queue has drained and then claims free external access slots from the slot timer. With those slots it fetches from one of three stores: a byte-wide tile memory, a colour memory or a scroll memory. It assembles a 16-bit word from what it fetched and then advances the access address by the auto-increment amount.

The colour and scroll stores do not implement every bit of a word. The bits they lack are filled from the last word the write queue committed, not from zeros. A tile word costs two access slots, one per byte. The commit port that fills the three stores belongs to the write path and is shared with this block. The processor side uses a request/ready handshake: it holds the request until ready pulses for one cycle with the data.

Top module: `vport_rd_engine`

## Requirements
- R1: Every accepted read, in either mode, pulses `pend_clr` high for exactly one cycle.
- R2: When `cmd_code[0]` is 1 (write mode), the read returns 0 with `rd_ready` in the cycle after acceptance. No slot is claimed and `addr_q` is left unchanged.
- R3: `slot_claim` does not rise for a new read until `fifo_empty` has been seen high, so a read never overtakes queued writes.
- R4: With code 4'b0000 (tile read), the block takes two slots. The first gives bits 15:8 from tile byte `addr_q[TILE_AW-1:0]`. The second gives bits 7:0 from that byte index XOR 1.
- R5: With code 4'b1000 (colour read), one slot is taken. The word at index `addr_q[6:1]` is returned ANDed with 16'h0EEE and ORed with the last committed value ANDed with 16'hF111.
- R6: With code 4'b0100 (scroll read), one slot is taken and the raw index is `addr_q[6:1]`. If that index is below 40, the stored word ANDed with 16'h03FF is returned, ORed with the last committed value ANDed with 16'hFC00. Otherwise the result is 0.
- R7: The last committed value resets to 0. It takes the commit data on every tile commit (`commit_sel`=0) and every colour commit (`commit_sel`=1). A scroll commit (`commit_sel`=2) updates it, and the store, only when `commit_addr[6:1]` is below 40.
- R8: Every read with `cmd_code[0]`=0 adds `autoinc` to `addr_q`, modulo 2^16. Any other read code with bit 0 clear takes one slot and returns 0.
- R9: `rd_ready` is a one-cycle pulse. While it is high, `slot_claim` is low and no new request is accepted.
- R10: After reset, `rd_ready`, `rd_data`, `slot_claim`, `pend_clr` and `addr_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Processor data-port read request, held until ready |
| rd_ready | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | 16 | Assembled read word |
| cmd_code | input | 4 | Latched command code (bit 0 = write mode) |
| addr_load | input | 1 | Load the access address from the control path |
| addr_load_val | input | 16 | Address value to load |
| autoinc | input | 8 | Auto-increment amount |
| addr_q | output | 16 | Current access address |
| pend_clr | output | 1 | Clears the control-word pending flag |
| fifo_empty | input | 1 | Write queue holds no entries |
| slot_pulse | input | 1 | A free external access slot occurs this cycle |
| slot_claim | output | 1 | Read waiting for, and claiming, the next slot |
| commit_we | input | 1 | Write queue commits a word this cycle |
| commit_sel | input | 2 | Commit target: 0 tile, 1 colour, 2 scroll |
| commit_addr | input | 16 | Commit address |
| commit_data | input | 16 | Commit data (tile uses bits 7:0) |

## Verification
Several properties are checked on every cycle. The ready and pending-clear pulses are single-cycle. A read never takes a slot while ready is high. Slot claims start only after the queue was seen empty. A write-mode read returns zero without moving the address. The last committed value stays put when nothing is committed. The bench scenarios are the only place where data content is shown. They show the byte order and XOR pairing of tile words, the stale upper bits in colour and scroll results, and the zero result for an out-of-range scroll index. They also show the slot count per read type, address wrap, a zero increment, and the skipped update on an out-of-range scroll commit.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  localparam int WORD_W = 16;

  localparam logic [3:0] CODE_TILE_RD   = 4'b0000;
  localparam logic [3:0] CODE_COLOUR_RD = 4'b1000;
  localparam logic [3:0] CODE_SCROLL_RD = 4'b0100;

  typedef enum logic [1:0] {
    TGT_TILE   = 2'd0,
    TGT_COLOUR = 2'd1,
    TGT_SCROLL = 2'd2,
    TGT_NONE   = 2'd3
  } tgt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_SLOT_A,
    ST_GOT_A,
    ST_SLOT_B,
    ST_GOT_B
  } seq_state_t;

  function automatic tgt_t read_target(input logic [3:0] code);
    case (code)
      CODE_TILE_RD:   return TGT_TILE;
      CODE_COLOUR_RD: return TGT_COLOUR;
      CODE_SCROLL_RD: return TGT_SCROLL;
      default:        return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vrd_store.sv
module vrd_store #(
  parameter int AW           = 16,
  parameter int TILE_AW      = 11,
  parameter int COLOUR_DEPTH = 64,
  parameter int SCROLL_DEPTH = 40,
  parameter int SCROLL_WIN_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit_we,
  input  logic [1:0]              commit_sel,
  input  logic [AW-1:0]           commit_addr,
  input  logic [15:0]             commit_data,
  input  logic [TILE_AW-1:0]      tile_idx,
  input  logic [AW-1:0]           word_addr,
  output logic [7:0]              tile_q,
  output logic [15:0]             colour_q,
  output logic [15:0]             scroll_q,
  output logic                    scroll_hit_q,
  output logic [15:0]             last_q
);
  localparam int TILE_DEPTH = 1 << TILE_AW;
  localparam int CI_W       = $clog2(COLOUR_DEPTH);
  localparam int SI_W       = $clog2(SCROLL_DEPTH);
  localparam logic [SCROLL_WIN_W:0] S_LIM = SCROLL_DEPTH[SCROLL_WIN_W:0];

  logic [7:0]  tile_mem   [TILE_DEPTH];
  logic [15:0] colour_mem [COLOUR_DEPTH];
  logic [15:0] scroll_mem [SCROLL_DEPTH];

  logic [SCROLL_WIN_W-1:0] c_sraw, r_sraw;
  logic                    c_shit, r_shit;
  logic                    wr_tile, wr_colour, wr_scroll;
  logic                    unused_addr_bits;

  assign c_sraw    = commit_addr[SCROLL_WIN_W:1];
  assign r_sraw    = word_addr[SCROLL_WIN_W:1];
  assign c_shit    = {1'b0, c_sraw} < S_LIM;
  assign r_shit    = {1'b0, r_sraw} < S_LIM;
  assign wr_tile   = commit_we && (commit_sel == 2'd0);
  assign wr_colour = commit_we && (commit_sel == 2'd1);
  assign wr_scroll = commit_we && (commit_sel == 2'd2) && c_shit;
  assign unused_addr_bits = ^{commit_addr, word_addr};

  // Memory ports kept free of reset so they map onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_tile) tile_mem[commit_addr[TILE_AW-1:0]] <= commit_data[7:0];
    tile_q <= tile_mem[tile_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_colour) colour_mem[commit_addr[CI_W:1]] <= commit_data;
    colour_q <= colour_mem[word_addr[CI_W:1]];
  end

  always_ff @(posedge clk) begin
    if (wr_scroll) scroll_mem[c_sraw[SI_W-1:0]] <= commit_data;
    scroll_q <= scroll_mem[r_sraw[SI_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) scroll_hit_q <= 1'b0;
    else     scroll_hit_q <= r_shit;
  end

  // R7: stale-bit source register
  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else if (wr_tile || wr_colour || wr_scroll) last_q <= commit_data;
  end

  a_r7_last_holds: assert property (@(posedge clk) disable iff (rst)
    !commit_we |=> $stable(last_q));
endmodule

// File: rtl/vrd_merge.sv
module vrd_merge
  import vrd_pkg::*;
#(
  parameter logic [15:0] COLOUR_MASK = 16'h0EEE,
  parameter logic [15:0] SCROLL_MASK = 16'h03FF
) (
  input  tgt_t        tgt,
  input  logic [7:0]  tile_hi,
  input  logic [7:0]  tile_lo,
  input  logic [15:0] colour_q,
  input  logic [15:0] scroll_q,
  input  logic        scroll_hit,
  input  logic [15:0] last_q,
  output logic [15:0] word
);
  always_comb begin
    case (tgt)
      TGT_TILE:   word = {tile_hi, tile_lo};
      TGT_COLOUR: word = (colour_q & COLOUR_MASK) | (last_q & ~COLOUR_MASK);
      TGT_SCROLL: word = scroll_hit ? ((scroll_q & SCROLL_MASK) | (last_q & ~SCROLL_MASK))
                                    : 16'h0000;
      default:    word = 16'h0000;
    endcase
  end
endmodule

// File: rtl/vrd_seq.sv
module vrd_seq
  import vrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_req,
  input  logic [3:0] cmd_code,
  input  logic       fifo_empty,
  input  logic       slot_pulse,
  output logic       rd_ready,
  output logic       pend_clr,
  output logic       slot_claim,
  output logic       finish,
  output logic       wr_fast,
  output logic       hi_cap,
  output logic       odd_byte,
  output tgt_t       tgt
);
  seq_state_t state_q, state_d;
  tgt_t       tgt_q;
  logic       accept;

  assign accept = (state_q == ST_IDLE) && rd_req && !rd_ready;
  assign wr_fast = accept && cmd_code[0];
  assign finish = (state_q == ST_GOT_B) || ((state_q == ST_GOT_A) && (tgt_q != TGT_TILE));
  assign hi_cap = (state_q == ST_GOT_A) && (tgt_q == TGT_TILE);
  assign odd_byte = (state_q == ST_SLOT_B);
  assign slot_claim = (state_q == ST_SLOT_A) || (state_q == ST_SLOT_B);
  assign tgt = tgt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept && !cmd_code[0]) state_d = ST_DRAIN;
      ST_DRAIN:  if (fifo_empty) state_d = ST_SLOT_A;
      ST_SLOT_A: if (slot_pulse) state_d = ST_GOT_A;
      ST_GOT_A:  state_d = (tgt_q == TGT_TILE) ? ST_SLOT_B : ST_IDLE;
      ST_SLOT_B: if (slot_pulse) state_d = ST_GOT_B;
      ST_GOT_B:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tgt_q    <= TGT_NONE;
      rd_ready <= 1'b0;
      pend_clr <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_clr <= accept;
      rd_ready <= wr_fast || finish;
      if (accept) tgt_q <= read_target(cmd_code);
    end
  end

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);
  a_r1_pend_pulse: assert property (@(posedge clk) disable iff (rst)
    pend_clr |=> !pend_clr);
  a_r9_no_claim_at_ready: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> !slot_claim);
  a_r3_claim_after_drain: assert property (@(posedge clk) disable iff (rst)
    ($rose(slot_claim) && !$past(hi_cap)) |-> $past(fifo_empty));
endmodule

// File: rtl/vport_rd_engine.sv
module vport_rd_engine
  import vrd_pkg::*;
#(
  parameter int          AW           = 16,
  parameter int          INC_W        = 8,
  parameter int          TILE_AW      = 11,
  parameter int          COLOUR_DEPTH = 64,
  parameter int          SCROLL_DEPTH = 40,
  parameter int          SCROLL_WIN_W = 6,
  parameter logic [15:0] COLOUR_MASK  = 16'h0EEE,
  parameter logic [15:0] SCROLL_MASK  = 16'h03FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  output logic             rd_ready,
  output logic [15:0]      rd_data,
  input  logic [3:0]       cmd_code,
  input  logic             addr_load,
  input  logic [AW-1:0]    addr_load_val,
  input  logic [INC_W-1:0] autoinc,
  output logic [AW-1:0]    addr_q,
  output logic             pend_clr,
  input  logic             fifo_empty,
  input  logic             slot_pulse,
  output logic             slot_claim,
  input  logic             commit_we,
  input  logic [1:0]       commit_sel,
  input  logic [AW-1:0]    commit_addr,
  input  logic [15:0]      commit_data
);
  localparam logic [AW-1:0] INC_PAD = '0;

  logic               finish, wr_fast, hi_cap, odd_byte;
  tgt_t               tgt;
  logic [TILE_AW-1:0] tile_idx;
  logic [7:0]         tile_q, hi_q;
  logic [15:0]        colour_q, scroll_q, last_q, merged;
  logic               scroll_hit_q;

  vrd_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .cmd_code   (cmd_code),
    .fifo_empty (fifo_empty),
    .slot_pulse (slot_pulse),
    .rd_ready   (rd_ready),
    .pend_clr   (pend_clr),
    .slot_claim (slot_claim),
    .finish     (finish),
    .wr_fast    (wr_fast),
    .hi_cap     (hi_cap),
    .odd_byte   (odd_byte),
    .tgt        (tgt)
  );

  // R4: second slot fetches the partner byte
  assign tile_idx = addr_q[TILE_AW-1:0] ^ {{(TILE_AW-1){1'b0}}, odd_byte};

  vrd_store #(
    .AW           (AW),
    .TILE_AW      (TILE_AW),
    .COLOUR_DEPTH (COLOUR_DEPTH),
    .SCROLL_DEPTH (SCROLL_DEPTH),
    .SCROLL_WIN_W (SCROLL_WIN_W)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .commit_we    (commit_we),
    .commit_sel   (commit_sel),
    .commit_addr  (commit_addr),
    .commit_data  (commit_data),
    .tile_idx     (tile_idx),
    .word_addr    (addr_q),
    .tile_q       (tile_q),
    .colour_q     (colour_q),
    .scroll_q     (scroll_q),
    .scroll_hit_q (scroll_hit_q),
    .last_q       (last_q)
  );

  vrd_merge #(
    .COLOUR_MASK (COLOUR_MASK),
    .SCROLL_MASK (SCROLL_MASK)
  ) u_merge (
    .tgt        (tgt),
    .tile_hi    (hi_q),
    .tile_lo    (tile_q),
    .colour_q   (colour_q),
    .scroll_q   (scroll_q),
    .scroll_hit (scroll_hit_q),
    .last_q     (last_q),
    .word       (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      rd_data <= '0;
      hi_q    <= '0;
    end else begin
      if (finish) addr_q <= addr_q + (INC_PAD | AW'(autoinc));
      else if (addr_load) addr_q <= addr_load_val;
      if (hi_cap) hi_q <= tile_q;
      if (wr_fast) rd_data <= '0;
      else if (finish) rd_data <= merged;
    end
  end

  a_r2_write_mode_zero: assert property (@(posedge clk) disable iff (rst)
    (pend_clr && cmd_code[0] && !$past(addr_load)) |-> (rd_ready && rd_data == 16'h0000 && addr_q == $past(addr_q)));
endmodule

// File: tb/vport_rd_engine_tb_top.sv
module vport_rd_engine_tb_top;
  localparam int TILE_DEPTH = 2048;

  typedef struct {
    logic [15:0] data;
    logic [15:0] addr;
    int          slots;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_data;
  logic [3:0]  cmd_code = 4'h0;
  logic        addr_load = 1'b0;
  logic [15:0] addr_load_val = '0;
  logic [7:0]  autoinc = 8'd2;
  logic [15:0] addr_q;
  logic        pend_clr;
  logic        fifo_empty = 1'b1;
  logic        slot_pulse = 1'b0;
  logic        slot_claim;
  logic        commit_we = 1'b0;
  logic [1:0]  commit_sel = '0;
  logic [15:0] commit_addr = '0;
  logic [15:0] commit_data = '0;

  int checks = 0, fails = 0, reads = 0;
  int slot_total = 0, slot_prev = 0, pend_total = 0;
  int slot_gap = 3, slot_cnt = 0;
  bit done = 0;
  exp_t sb[$];

  logic [7:0]  m_tile [TILE_DEPTH];
  logic [15:0] m_col  [64];
  logic [15:0] m_scr  [64];
  logic [15:0] m_last = 16'h0000;
  logic [15:0] m_addr = 16'h0000;

  always #5 clk = ~clk;

  vport_rd_engine dut_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_ready(rd_ready), .rd_data(rd_data),
    .cmd_code(cmd_code), .addr_load(addr_load), .addr_load_val(addr_load_val),
    .autoinc(autoinc), .addr_q(addr_q), .pend_clr(pend_clr), .fifo_empty(fifo_empty),
    .slot_pulse(slot_pulse), .slot_claim(slot_claim), .commit_we(commit_we),
    .commit_sel(commit_sel), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (slot_cnt + 1 >= slot_gap) slot_cnt <= 0;
    else slot_cnt <= slot_cnt + 1;
    slot_pulse <= (slot_cnt == 0);
  end

  always @(posedge clk) begin
    if (!rst && slot_claim && slot_pulse) slot_total <= slot_total + 1;
    if (!rst && pend_clr) pend_total <= pend_total + 1;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_ready) begin
      if (sb.size() == 0) begin
        check(0, "R9 unexpected ready", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rd_data == e.data, {e.req, " data"}, rd_data, e.data);
        check(addr_q == e.addr, {e.req, " R8 address"}, addr_q, e.addr);
        check(slot_total - slot_prev == e.slots, {e.req, " slot count"}, slot_total - slot_prev, e.slots);
      end
      slot_prev = slot_total;
    end
  end

  task automatic commit(input logic [1:0] sel, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    commit_we = 1'b1; commit_sel = sel; commit_addr = a; commit_data = d;
    @(negedge clk);
    commit_we = 1'b0;
    case (sel)
      2'd0: begin m_tile[a[10:0]] = d[7:0]; m_last = d; end
      2'd1: begin m_col[a[6:1]] = d; m_last = d; end
      2'd2: if (a[6:1] < 6'd40) begin m_scr[a[6:1]] = d; m_last = d; end
      default: ;
    endcase
  endtask

  task automatic set_addr(input logic [3:0] code, input logic [15:0] a, input logic [7:0] inc);
    @(negedge clk);
    cmd_code = code; autoinc = inc; addr_load = 1'b1; addr_load_val = a;
    @(negedge clk);
    addr_load = 1'b0;
    m_addr = a;
  endtask

  function automatic exp_t predict(input logic [3:0] code, input string req);
    exp_t e;
    logic [5:0] wi;
    wi = m_addr[6:1];
    e.req = req;
    e.slots = 1;
    e.data = 16'h0000;
    if (code[0]) begin
      e.slots = 0;
      e.addr = m_addr;
      return e;
    end
    case (code)
      4'b0000: begin
        e.slots = 2;
        e.data = {m_tile[m_addr[10:0]], m_tile[m_addr[10:0] ^ 11'd1]};
      end
      4'b1000: e.data = (m_col[wi] & 16'h0EEE) | (m_last & 16'hF111);
      4'b0100: e.data = (wi < 6'd40) ? ((m_scr[wi] & 16'h03FF) | (m_last & 16'hFC00)) : 16'h0000;
      default: e.data = 16'h0000;
    endcase
    e.addr = m_addr + {8'h00, autoinc};
    return e;
  endfunction

  task automatic run_read(input string req, input int drain_delay);
    exp_t e;
    e = predict(cmd_code, req);
    m_addr = e.addr;
    sb.push_back(e);
    reads++;
    @(negedge clk);
    if (drain_delay > 0) fifo_empty = 1'b0;
    rd_req = 1'b1;
    if (drain_delay > 0) begin
      bit seen;
      seen = 0;
      for (int i = 0; i < drain_delay; i++) begin
        @(negedge clk);
        if (slot_claim || rd_ready) seen = 1;
      end
      check(!seen, "R3 claim before drain", seen, 0);
      fifo_empty = 1'b1;
    end
    do @(negedge clk); while (!rd_ready);
    rd_req = 1'b0;
    @(negedge clk);
    check(!rd_ready, "R9 ready single cycle", rd_ready, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(rd_ready == 0, "R10 rd_ready", rd_ready, 0);
    check(rd_data == 0, "R10 rd_data", rd_data, 0);
    check(slot_claim == 0, "R10 slot_claim", slot_claim, 0);
    check(pend_clr == 0, "R10 pend_clr", pend_clr, 0);
    check(addr_q == 0, "R10 addr_q", addr_q, 0);

    commit(2'd0, 16'h0010, 16'h00A1);
    commit(2'd0, 16'h0011, 16'h00B2);
    commit(2'd0, 16'h0012, 16'h00C3);
    commit(2'd0, 16'h0013, 16'h00D4);
    commit(2'd0, 16'h07FF, 16'h005A);
    commit(2'd0, 16'hFFFE, 16'h003C);
    commit(2'd2, 16'h0002, 16'hF123);
    commit(2'd1, 16'h0004, 16'h5ABC);

    set_addr(4'b0000, 16'h0010, 8'd2);
    run_read("R4 tile even", 0);
    run_read("R4 tile continued", 0);
    set_addr(4'b0000, 16'h0011, 8'd1);
    run_read("R4 tile odd xor", 0);

    set_addr(4'b1000, 16'h0004, 8'd2);
    run_read("R5 colour stale bits", 0);
    commit(2'd0, 16'h0100, 16'hFFFF);
    set_addr(4'b1000, 16'h0004, 8'd2);
    run_read("R7 tile commit sets last, R5 colour", 0);

    slot_gap = 5;
    set_addr(4'b0100, 16'h0002, 8'd2);
    run_read("R6 scroll in range", 0);
    set_addr(4'b0100, 16'h0050, 8'd2);
    run_read("R6 scroll out of range", 0);

    commit(2'd2, 16'h0052, 16'h1234);
    set_addr(4'b0100, 16'h0002, 8'd0);
    run_read("R7 out-of-range scroll commit ignored", 0);

    set_addr(4'b0001, 16'h0200, 8'd2);
    run_read("R2 write mode", 0);
    set_addr(4'b0010, 16'h0300, 8'd6);
    run_read("R8 other read code", 0);

    set_addr(4'b0000, 16'hFFFF, 8'd4);
    run_read("R8 tile wrap", 0);

    slot_gap = 2;
    set_addr(4'b1000, 16'h0004, 8'd2);
    run_read("R3 read after drain", 8);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9 all reads answered", sb.size(), 0);
    check(pend_total == reads, "R1 pend_clr per read", pend_total, reads);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule